// File: doc/BRIEF.md
# Link Packet Framer and Integrity Checker

This block frames outgoing packets and checks incoming ones on a 16-bit link that moves one word per clock. The transmit half takes a payload of 4 to 32 words (8 to 64 bytes) from a valid/ready stream. It puts out a start marker word, the payload words, a 16-bit checksum word and an end marker word, all on consecutive cycles while the source keeps up.

The receive half watches the link for the start marker and records the packet class from a side input at that moment. It passes payload words on as they are confirmed not to be the checksum, recomputes the checksum and waits for the end marker. One cycle after the packet closes it gives a verdict. A good packet of either class raises a success pulse. A good control packet also raises an acknowledge request. A failed data packet raises a drop pulse, which tells the consumer to discard the words it was given. A failed control packet raises a negative-acknowledge request so the far end sends it again.

Top module: `frm_link_codec`

## Requirements
- R1: After `tx_valid` rises, the link output carries, on valid cycles in this order: the start word 16'hFB5A, each payload word in the order it was accepted, the checksum word, then the end word 16'hFD7C. The checksum and end word come on the two cycles right after the last payload word.
- R2: `tx_ready` is low while the start, checksum and end words are sent and after reset. It is high only while payload words are accepted. `link_tx_valid` is low when no packet is in flight.
- R3: The checksum runs over the payload words only. It uses polynomial 0x1021 with start value 0xFFFF and takes each word most significant bit first, with no final inversion.
- R4: The receiver puts every payload word out on `rx_word` with a one-cycle `rx_word_valid`, in order. The checksum and end words are never delivered, and no word pulse falls in the same cycle as a verdict.
- R5: A received packet whose payload has fewer than 4 words fails. A packet whose words after the start marker run past 33 without an end word is closed as failed one cycle after the 34th such word. A payload of 4 to 32 words with a correct checksum passes.
- R6: A good packet gives exactly one `rx_ok` pulse, in the cycle after the end word is taken.
- R7: A failed data-class packet (`rx_ctrl` low at the start word) gives one `rx_drop` pulse, with no `rx_ok` and no `rx_nack_req`.
- R8: A good control-class packet (`rx_ctrl` high at the start word) gives one `rx_ack_req` pulse together with its `rx_ok`. A failed one gives one `rx_nack_req` pulse and no acknowledge.
- R9: Link words other than the start word are ignored outside a packet. Cycles with `link_rx_valid` low inside a packet change neither its content nor its verdict.
- R10: After reset every output of the block is low.
- R11: The packet class is taken only with the start word. Changes on `rx_ctrl` later in the packet have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit payload word present |
| tx_data | input | 16 | Transmit payload word |
| tx_last | input | 1 | Marks the final payload word |
| tx_ready | output | 1 | Payload word accepted this cycle when valid |
| link_tx_valid | output | 1 | Link output word valid |
| link_tx_data | output | 16 | Link output word |
| link_rx_valid | input | 1 | Link input word valid |
| link_rx_data | input | 16 | Link input word |
| rx_ctrl | input | 1 | Packet class at the start word: 1 control, 0 data |
| rx_word_valid | output | 1 | Received payload word valid |
| rx_word | output | 16 | Received payload word |
| rx_ok | output | 1 | Packet passed |
| rx_drop | output | 1 | Data packet failed, discard it |
| rx_ack_req | output | 1 | Request to acknowledge a control packet |
| rx_nack_req | output | 1 | Request to negatively acknowledge a control packet |

## Verification
The bench aims at the length edges: a 3-word payload and a 33-word payload must fail, and a 32-word payload must pass. A receiver with an off-by-one bound would pass the short packet or reject the full one. It flips the checksum in each class, so a design that ties the response to the wrong class, or to the class input at the end of the packet rather than at the start, shows up as a drop where a retransmit request was due. Gaps in the link stream, stray end words on an idle link and a transmit stall in mid-payload show whether a design counts or checksums cycles that carry no word. The acknowledge pulse is timed to the cycle after the end word, so a late or stretched pulse fails.

// File: rtl/frm_pkg.sv
package frm_pkg;

  localparam int unsigned FRM_W = 16;

  localparam logic [FRM_W-1:0] FRM_SOP_DEF  = 16'hFB5A;
  localparam logic [FRM_W-1:0] FRM_EOP_DEF  = 16'hFD7C;
  localparam logic [FRM_W-1:0] CRC_POLY_DEF = 16'h1021;
  localparam logic [FRM_W-1:0] CRC_INIT_DEF = 16'hFFFF;

  typedef enum logic [1:0] {TX_IDLE, TX_BODY, TX_CRC, TX_EOP} tx_state_e;
  typedef enum logic {RX_IDLE, RX_BODY} rx_state_e;

  // One word folded into the running checksum, most significant bit first.
  function automatic logic [FRM_W-1:0] crc_fold(input logic [FRM_W-1:0] cur,
                                                input logic [FRM_W-1:0] word,
                                                input logic [FRM_W-1:0] poly);
    logic [FRM_W-1:0] r;
    r = cur;
    for (int b = FRM_W - 1; b >= 0; b--) begin
      if (r[FRM_W-1] ^ word[b]) r = {r[FRM_W-2:0], 1'b0} ^ poly;
      else                      r = {r[FRM_W-2:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/frm_crc16.sv
module frm_crc16
  import frm_pkg::*;
#(
  parameter logic [FRM_W-1:0] POLY = CRC_POLY_DEF,
  parameter logic [FRM_W-1:0] INIT = CRC_INIT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [FRM_W-1:0] din,
  output logic [FRM_W-1:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= INIT;
    else if (en)    crc <= crc_fold(crc, din, POLY);
  end

endmodule

// File: rtl/frm_tx.sv
module frm_tx
  import frm_pkg::*;
#(
  parameter logic [FRM_W-1:0] SOP_WORD = FRM_SOP_DEF,
  parameter logic [FRM_W-1:0] EOP_WORD = FRM_EOP_DEF,
  parameter logic [FRM_W-1:0] POLY     = CRC_POLY_DEF,
  parameter logic [FRM_W-1:0] INIT     = CRC_INIT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_valid,
  input  logic [FRM_W-1:0] tx_data,
  input  logic             tx_last,
  output logic             tx_ready,
  output logic             link_valid,
  output logic [FRM_W-1:0] link_data
);

  tx_state_e        st;
  logic [FRM_W-1:0] crc_q;
  logic             take;

  assign tx_ready = (st == TX_BODY);
  assign take     = tx_ready && tx_valid;

  frm_crc16 #(.POLY(POLY), .INIT(INIT)) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (st == TX_IDLE),
    .en  (take),
    .din (tx_data),
    .crc (crc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= TX_IDLE;
      link_valid <= 1'b0;
      link_data  <= '0;
    end else begin
      link_valid <= 1'b0;
      unique case (st)
        TX_IDLE: if (tx_valid) begin
          link_valid <= 1'b1;
          link_data  <= SOP_WORD;
          st         <= TX_BODY;
        end
        TX_BODY: if (take) begin
          link_valid <= 1'b1;
          link_data  <= tx_data;
          if (tx_last) st <= TX_CRC;
        end
        TX_CRC: begin
          link_valid <= 1'b1;
          link_data  <= crc_q;
          st         <= TX_EOP;
        end
        TX_EOP: begin
          link_valid <= 1'b1;
          link_data  <= EOP_WORD;
          st         <= TX_IDLE;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R2: payload acceptance opens only right after the start word went out
  a_r2_ready_after_sop: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ready) |-> (link_valid && link_data == SOP_WORD));

  // R1: checksum then end word follow the last payload word back to back
  a_r1_trailer_follows: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_ready) |=> link_valid ##1 (link_valid && link_data == EOP_WORD));

endmodule

// File: rtl/frm_rx.sv
module frm_rx
  import frm_pkg::*;
#(
  parameter int unsigned      MIN_WORDS = 4,
  parameter int unsigned      MAX_WORDS = 32,
  parameter logic [FRM_W-1:0] SOP_WORD  = FRM_SOP_DEF,
  parameter logic [FRM_W-1:0] EOP_WORD  = FRM_EOP_DEF,
  parameter logic [FRM_W-1:0] POLY      = CRC_POLY_DEF,
  parameter logic [FRM_W-1:0] INIT      = CRC_INIT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_valid,
  input  logic [FRM_W-1:0] link_data,
  input  logic             cls_in,
  output logic             word_valid,
  output logic [FRM_W-1:0] word,
  output logic             ok,
  output logic             drop,
  output logic             ack_req,
  output logic             nack_req
);

  localparam int unsigned    CW    = $clog2(MAX_WORDS + 1);
  localparam logic [CW-1:0]  MIN_C = CW'(MIN_WORDS);
  localparam logic [CW-1:0]  MAX_C = CW'(MAX_WORDS);

  rx_state_e        st;
  logic             cls_q;
  logic [FRM_W-1:0] hold;
  logic             have_hold;
  logic [CW-1:0]    cnt;
  logic [FRM_W-1:0] crc_q;

  logic start, acc, is_eop, fold, overrun, fin, good, bad;

  assign start   = (st == RX_IDLE) && link_valid && (link_data == SOP_WORD);
  assign acc     = (st == RX_BODY) && link_valid;
  assign is_eop  = (link_data == EOP_WORD);
  assign fold    = acc && !is_eop && have_hold && (cnt != MAX_C);
  assign overrun = acc && !is_eop && have_hold && (cnt == MAX_C);
  assign fin     = acc && is_eop;
  assign good    = fin && have_hold && (crc_q == hold) && (cnt >= MIN_C);
  assign bad     = (fin && !good) || overrun;

  frm_crc16 #(.POLY(POLY), .INIT(INIT)) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .en  (fold),
    .din (hold),
    .crc (crc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RX_IDLE;
      cls_q     <= 1'b0;
      hold      <= '0;
      have_hold <= 1'b0;
      cnt       <= '0;
    end else begin
      if (start) begin
        st        <= RX_BODY;
        cls_q     <= cls_in;
        have_hold <= 1'b0;
        cnt       <= '0;
      end else if (fin || overrun) begin
        st <= RX_IDLE;
      end else if (acc) begin
        hold      <= link_data;
        have_hold <= 1'b1;
        if (fold) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_valid <= 1'b0;
      word       <= '0;
      ok         <= 1'b0;
      drop       <= 1'b0;
      ack_req    <= 1'b0;
      nack_req   <= 1'b0;
    end else begin
      word_valid <= fold;
      if (fold) word <= hold;
      ok       <= good;
      ack_req  <= good && cls_q;
      drop     <= bad && !cls_q;
      nack_req <= bad && cls_q;
    end
  end

  // R6: one verdict kind at a time
  a_r6_single_verdict: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ok, drop, nack_req}));

  // R8: an acknowledge request only comes with a passing packet
  a_r8_ack_with_ok: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> ok);

  // R4: delivered words never share a cycle with a verdict
  a_r4_word_apart: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> !(ok || drop || nack_req));

  // R5: an overlong packet is closed as failed on the next cycle
  a_r5_overrun_flagged: assert property (@(posedge clk) disable iff (rst)
    ((st == RX_BODY) && link_valid && !is_eop && have_hold && cnt == MAX_C)
      |=> (drop || nack_req));

endmodule

// File: rtl/frm_link_codec.sv
module frm_link_codec
  import frm_pkg::*;
#(
  parameter int unsigned      MIN_WORDS = 4,
  parameter int unsigned      MAX_WORDS = 32,
  parameter logic [FRM_W-1:0] SOP_WORD  = FRM_SOP_DEF,
  parameter logic [FRM_W-1:0] EOP_WORD  = FRM_EOP_DEF,
  parameter logic [FRM_W-1:0] CRC_POLY  = CRC_POLY_DEF,
  parameter logic [FRM_W-1:0] CRC_INIT  = CRC_INIT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_valid,
  input  logic [FRM_W-1:0] tx_data,
  input  logic             tx_last,
  output logic             tx_ready,
  output logic             link_tx_valid,
  output logic [FRM_W-1:0] link_tx_data,
  input  logic             link_rx_valid,
  input  logic [FRM_W-1:0] link_rx_data,
  input  logic             rx_ctrl,
  output logic             rx_word_valid,
  output logic [FRM_W-1:0] rx_word,
  output logic             rx_ok,
  output logic             rx_drop,
  output logic             rx_ack_req,
  output logic             rx_nack_req
);

  frm_tx #(
    .SOP_WORD (SOP_WORD),
    .EOP_WORD (EOP_WORD),
    .POLY     (CRC_POLY),
    .INIT     (CRC_INIT)
  ) u_tx (
    .clk        (clk),
    .rst        (rst),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .tx_ready   (tx_ready),
    .link_valid (link_tx_valid),
    .link_data  (link_tx_data)
  );

  frm_rx #(
    .MIN_WORDS (MIN_WORDS),
    .MAX_WORDS (MAX_WORDS),
    .SOP_WORD  (SOP_WORD),
    .EOP_WORD  (EOP_WORD),
    .POLY      (CRC_POLY),
    .INIT      (CRC_INIT)
  ) u_rx (
    .clk        (clk),
    .rst        (rst),
    .link_valid (link_rx_valid),
    .link_data  (link_rx_data),
    .cls_in     (rx_ctrl),
    .word_valid (rx_word_valid),
    .word       (rx_word),
    .ok         (rx_ok),
    .drop       (rx_drop),
    .ack_req    (rx_ack_req),
    .nack_req   (rx_nack_req)
  );

endmodule

// File: tb/frm_link_codec_tb_top.sv
module frm_link_codec_tb_top;

  localparam logic [15:0] SOP = 16'hFB5A;
  localparam logic [15:0] EOP = 16'hFD7C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        tx_valid = 1'b0, tx_last = 1'b0;
  logic [15:0] tx_data  = '0;
  logic        tx_ready;
  logic        link_tx_valid;
  logic [15:0] link_tx_data;
  logic        loop = 1'b0;
  logic        drv_valid = 1'b0;
  logic [15:0] drv_data = '0;
  logic        rx_ctrl = 1'b0;
  logic        link_rx_valid;
  logic [15:0] link_rx_data;
  logic        rx_word_valid, rx_ok, rx_drop, rx_ack_req, rx_nack_req;
  logic [15:0] rx_word;

  assign link_rx_valid = loop ? link_tx_valid : drv_valid;
  assign link_rx_data  = loop ? link_tx_data  : drv_data;

  frm_link_codec dut_i (
    .clk           (clk),
    .rst           (rst),
    .tx_valid      (tx_valid),
    .tx_data       (tx_data),
    .tx_last       (tx_last),
    .tx_ready      (tx_ready),
    .link_tx_valid (link_tx_valid),
    .link_tx_data  (link_tx_data),
    .link_rx_valid (link_rx_valid),
    .link_rx_data  (link_rx_data),
    .rx_ctrl       (rx_ctrl),
    .rx_word_valid (rx_word_valid),
    .rx_word       (rx_word),
    .rx_ok         (rx_ok),
    .rx_drop       (rx_drop),
    .rx_ack_req    (rx_ack_req),
    .rx_nack_req   (rx_nack_req)
  );

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor state
  logic [15:0] rxw [0:63];
  logic [15:0] txc [0:63];
  int nrw = 0, ntx = 0;
  int n_ok = 0, n_drop = 0, n_ack = 0, n_nack = 0;
  int vcyc = -1, acyc = -1;

  always @(negedge clk) if (!rst) begin
    if (rx_word_valid) begin if (nrw < 64) rxw[nrw] = rx_word; nrw++; end
    if (link_tx_valid) begin if (ntx < 64) txc[ntx] = link_tx_data; ntx++; end
    if (rx_ok)       n_ok++;
    if (rx_drop)     n_drop++;
    if (rx_ack_req)  begin n_ack++; acyc = cyc; end
    if (rx_nack_req) n_nack++;
    if (rx_ok || rx_drop || rx_nack_req) vcyc = cyc;
  end

  logic [15:0] pay [0:63];
  logic [15:0] fr  [0:63];
  int          frn;
  int          last_cyc;

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  function automatic logic [15:0] mcrc(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r = c;
    for (int b = 15; b >= 0; b--) begin
      logic fb = r[15] ^ w[b];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic mk_payload(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) pay[i] = base + 16'(i) * 16'h0113;
  endtask

  function automatic logic [15:0] pay_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) c = mcrc(c, pay[i]);
    return c;
  endfunction

  task automatic mk_frame(input int n, input bit bad_crc);
    fr[0] = SOP;
    for (int i = 0; i < n; i++) fr[i+1] = pay[i];
    fr[n+1] = pay_crc(n) ^ (bad_crc ? 16'h0001 : 16'h0000);
    fr[n+2] = EOP;
    frn = n + 3;
  endtask

  task automatic clr_mon();
    repeat (3) @(negedge clk);
    nrw = 0; ntx = 0; n_ok = 0; n_drop = 0; n_ack = 0; n_nack = 0;
    vcyc = -1; acyc = -1;
  endtask

  // drive fr[] onto the link input; class given at SOP and another later
  task automatic drive_raw(input bit cls_sop, input bit cls_rest, input int gap_at);
    for (int i = 0; i < frn; i++) begin
      if (i == gap_at) begin @(negedge clk); drv_valid = 1'b0; end
      @(negedge clk);
      drv_valid = 1'b1;
      drv_data  = fr[i];
      rx_ctrl   = (i == 0) ? cls_sop : cls_rest;
      last_cyc  = cyc;
    end
    @(negedge clk);
    drv_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // send pay[0..n-1] through the transmit port, optional one-cycle stall
  task automatic drive_tx(input int n, input int stall_at);
    int  i = 0;
    bit  r;
    bit  stalled = 0;
    bit  first = 1;
    @(negedge clk);
    tx_valid = 1'b1;
    while (i < n) begin
      if (i == stall_at && !stalled && !first) begin
        tx_valid = 1'b0; stalled = 1;
        @(negedge clk);
        tx_valid = 1'b1;
      end
      tx_data = pay[i];
      tx_last = (i == n - 1);
      r = tx_ready;
      if (first) check(r == 1'b0, "R2", "tx_ready during start word", int'(r), 0);
      first = 0;
      @(negedge clk);
      if (r) i++;
    end
    tx_valid = 1'b0;
    tx_last  = 1'b0;
    check(tx_ready == 1'b0, "R2", "tx_ready during checksum word", int'(tx_ready), 0);
    repeat (6) @(negedge clk);
    check(link_tx_valid == 1'b0, "R2", "link idle after packet", int'(link_tx_valid), 0);
  endtask

  task automatic t_reset();
    check({tx_ready, link_tx_valid, rx_word_valid, rx_ok, rx_drop, rx_ack_req,
           rx_nack_req} == 7'b0, "R10", "outputs after reset",
          int'({tx_ready, link_tx_valid, rx_word_valid, rx_ok, rx_drop,
                rx_ack_req, rx_nack_req}), 0);
  endtask

  task automatic t_tx_frame(input int n, input int stall_at, input bit cls);
    clr_mon();
    loop = 1'b1;
    rx_ctrl = cls;
    mk_payload(n, 16'h1200 + 16'(n));
    drive_tx(n, stall_at);
    check(ntx == n + 3, "R1", "link word count", ntx, n + 3);
    check(txc[0] == SOP, "R1", "start word", int'(txc[0]), int'(SOP));
    for (int i = 0; i < n; i++)
      if (txc[i+1] != pay[i])
        check(0, "R1", "payload word order", int'(txc[i+1]), int'(pay[i]));
    check(txc[n+1] == pay_crc(n), "R3", "checksum word", int'(txc[n+1]), int'(pay_crc(n)));
    check(txc[n+2] == EOP, "R1", "end word", int'(txc[n+2]), int'(EOP));
    check(nrw == n, "R4", "loopback words delivered", nrw, n);
    for (int i = 0; i < n; i++)
      if (rxw[i] != pay[i])
        check(0, "R4", "loopback word value", int'(rxw[i]), int'(pay[i]));
    check(n_ok == 1 && n_drop == 0 && n_nack == 0, "R6", "loopback verdict ok count", n_ok, 1);
    check(n_ack == (cls ? 1 : 0), "R8", "loopback ack count", n_ack, cls ? 1 : 0);
    loop = 1'b0;
  endtask

  task automatic t_ctrl_good_max();
    clr_mon();
    mk_payload(32, 16'h2000);
    mk_frame(32, 0);
    drive_raw(1, 1, -1);
    check(n_ok == 1, "R5", "32-word payload passes", n_ok, 1);
    check(n_ack == 1 && acyc == last_cyc + 1, "R8", "ack pulse cycle after end word",
          acyc, last_cyc + 1);
    check(vcyc == last_cyc + 1, "R6", "ok pulse timing", vcyc, last_cyc + 1);
    check(nrw == 32, "R4", "checksum word not delivered", nrw, 32);
  endtask

  task automatic t_ctrl_bad();
    clr_mon();
    mk_payload(6, 16'h3000);
    mk_frame(6, 1);
    drive_raw(1, 1, -1);
    check(n_nack == 1 && n_ack == 0 && n_ok == 0 && n_drop == 0, "R8",
          "bad control packet gives nack only", n_nack, 1);
  endtask

  task automatic t_data_bad_gap();
    clr_mon();
    mk_payload(5, 16'h3300);
    mk_frame(5, 1);
    drive_raw(0, 0, 3);
    check(n_drop == 1 && n_nack == 0 && n_ok == 0, "R7", "bad data packet dropped",
          n_drop, 1);
    check(vcyc == last_cyc + 1, "R7", "drop pulse timing", vcyc, last_cyc + 1);
  endtask

  task automatic t_data_good_gap();
    clr_mon();
    mk_payload(4, 16'h0400);
    mk_frame(4, 0);
    drive_raw(0, 1, 2);
    check(n_ok == 1 && n_drop == 0 && n_ack == 0, "R9", "gap inside packet ignored",
          n_ok, 1);
    check(nrw == 4 && rxw[3] == pay[3], "R9", "words across gap", nrw, 4);
  endtask

  task automatic t_short();
    clr_mon();
    mk_payload(3, 16'h4000);
    mk_frame(3, 0);
    drive_raw(0, 0, -1);
    check(n_drop == 1 && n_ok == 0, "R5", "3-word payload fails", n_drop, 1);
  endtask

  task automatic t_long();
    clr_mon();
    mk_payload(33, 16'h5000);
    mk_frame(33, 0);
    frn = 35;              // stop after the 34th word, the end word is never sent
    drive_raw(0, 0, -1);
    check(n_drop == 1 && n_ok == 0, "R5", "33-word payload fails", n_drop, 1);
    check(vcyc == last_cyc + 1, "R5", "overrun verdict timing", vcyc, last_cyc + 1);
    check(nrw == 32, "R5", "words before overrun", nrw, 32);
  endtask

  task automatic t_idle_noise();
    clr_mon();
    fr[0] = EOP; fr[1] = 16'h1234; fr[2] = EOP; fr[3] = 16'h0000;
    frn = 4;
    drive_raw(1, 1, -1);
    check(nrw == 0 && n_ok + n_drop + n_nack + n_ack == 0, "R9",
          "idle words ignored", nrw + n_ok + n_drop + n_nack + n_ack, 0);
  endtask

  task automatic t_class_latch();
    clr_mon();
    mk_payload(7, 16'h6000);
    mk_frame(7, 1);
    drive_raw(1, 0, -1);
    check(n_nack == 1 && n_drop == 0, "R11", "class kept from start word", n_nack, 1);
    clr_mon();
    mk_frame(7, 0);
    drive_raw(0, 1, -1);
    check(n_ok == 1 && n_ack == 0, "R11", "no ack for data class", n_ack, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx_frame(5, -1, 0);
    t_tx_frame(32, 10, 1);
    t_ctrl_good_max();
    t_ctrl_bad();
    t_data_bad_gap();
    t_data_good_gap();
    t_short();
    t_long();
    t_idle_noise();
    t_class_latch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule